// File: doc/BRIEF.md
# Activation-Count Victim Row Refresher

This block watches the row activations issued to one small bank of DRAM rows and decides which rows are being disturbed by heavy use of their neighbours. Each activation adds to a saturating counter for its row. A free-running window timer clears every counter together when a programmable number of cycles has passed. Software sets the window length, and it is chosen no longer than the nominal 64 ms background refresh period.

A row becomes a victim when the activations of its two neighbours add up to the programmable limit inside one window. Heavy use of a single neighbour reaches the limit the same way, and so does use spread over both neighbours. Victims go into a short queue of refresh requests. Each queued request is offered to the command scheduler through a valid/ready handshake. When the scheduler accepts a request, the counters of the victim's neighbours drop to zero, so the same request is not raised again.

Top module: `victim_row_refresher`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `ref_valid` is low. All counters, the window timer and the queue start empty.
- R2: Activations on row A count toward the victims A-1 and A+1. When A's count reaches `act_limit`, both of those rows are queued. Rows that become victims together are queued one per cycle, lowest row number first, and are served in queue order.
- R3: A row v is also queued when count(v-1) + count(v+1) reaches `act_limit`, even if each count alone is below the limit.
- R4: Row 0 has row 1 as its only neighbour, and row NUM_ROWS-1 has row NUM_ROWS-2 as its only one. An activation whose address is NUM_ROWS or higher changes no counter. `ref_row` is always below NUM_ROWS.
- R5: The window timer counts clock cycles from reset. In each cycle where it reaches `win_cycles`-1, every counter is cleared at the next edge and the timer restarts from 0. An activation in that same cycle counts as 1 in the new window.
- R6: A request is consumed in any cycle where `ref_valid` and `ref_ready` are both high. At that edge the counters of the served row's neighbours clear to zero, and an activation in the same cycle still counts as 1. The served row is no longer marked as pending.
- R7: A row that is already waiting in the queue is not queued again. Pending requests survive a window expiry.
- R8: The queue holds at most DEPTH requests. A victim found while the queue is full waits and is queued once space frees up. While `ref_valid` is high and `ref_ready` is low, `ref_row` stays stable.
- R9: Counters saturate at 2^CNT_W-1 and never wrap. A row hammered past that value keeps its neighbours at risk.
- R10: An `act_limit` of 0 turns detection off: no row is queued while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| act_valid | input | 1 | Row activation strobe |
| act_row | input | ROW_W | Row address of the activation |
| act_limit | input | CNT_W | Activation limit per window (0 turns detection off) |
| win_cycles | input | WIN_W | Window length in clock cycles |
| ref_valid | output | 1 | A refresh request is offered |
| ref_row | output | ROW_W | Victim row to be refreshed |
| ref_ready | input | 1 | Scheduler accepts the offered request |

## Verification
The bench builds the block with 12 rows, 4-bit counters and a queue three entries deep. With 12 rows, the 4-bit address can also carry out-of-range values 12 to 15. The 4-bit counters let saturation at 15 be reached in a few activations. The shallow queue fills with just two hammered aggressors, which exposes both the wait-for-space behaviour and duplicate suppression. Short windows of 20 to 40 cycles put several expiries, including ones that coincide with activations, inside each test.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

    localparam int unsigned DEF_ROWS  = 16;
    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_WIN_W = 24;
    localparam int unsigned DEF_DEPTH = 4;

    // Per-row counter control for one cycle
    typedef struct packed {
        logic hit;   // activation addressed to this row
        logic wipe;  // counter returns to zero before the hit is added
    } cnt_op_t;

    // Saturating step: adds one unless already at the ceiling
    function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                             input logic        inc,
                                             input logic [31:0] ceil);
        if (inc && cur < ceil) return cur + 32'd1;
        return cur;
    endfunction

    // Combined neighbour pressure against the limit; limit 0 disables
    function automatic logic at_risk(input logic [31:0] lo,
                                     input logic [31:0] hi,
                                     input logic [31:0] limit);
        if (limit == 32'd0) return 1'b0;
        return (lo + hi) >= limit;
    endfunction

endpackage

// File: rtl/vrr_window_timer.sv
module vrr_window_timer #(
    parameter int unsigned WIN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             expire
);
    logic [WIN_W-1:0] tick_q;

    assign expire = ({1'b0, tick_q} + (WIN_W+1)'(1)) >= {1'b0, win_cycles};

    always_ff @(posedge clk) begin
        if (rst)         tick_q <= '0;
        else if (expire) tick_q <= '0;
        else             tick_q <= tick_q + WIN_W'(1);
    end
endmodule

// File: rtl/vrr_count_bank.sv
module vrr_count_bank
    import vrr_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned ROW_W = 4,
    parameter int unsigned CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               act_valid,
    input  logic [ROW_W-1:0]   act_row,
    input  logic               expire,
    input  logic               clr_valid,
    input  logic [ROW_W-1:0]   clr_row,
    output logic [N*CNT_W-1:0] cnt_flat
);
    localparam logic [31:0] CEIL = 32'((64'd1 << CNT_W) - 64'd1);

    for (genvar r = 0; r < N; r++) begin : g_row
        cnt_op_t          op;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] base;

        always_comb begin
            op.hit  = act_valid && (32'(act_row) == 32'(r));
            op.wipe = expire ||
                      (clr_valid && ((32'(clr_row) + 32'd1 == 32'(r)) ||
                                     (32'(clr_row) == 32'(r) + 32'd1)));
            base    = op.wipe ? '0 : cnt_q;
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= CNT_W'(sat_step(32'(base), op.hit, CEIL));
        end

        assign cnt_flat[r*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/vrr_risk_detect.sv
module vrr_risk_detect
    import vrr_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic [N*CNT_W-1:0] cnt_flat,
    input  logic [CNT_W-1:0]   limit,
    output logic [N-1:0]       risk
);
    for (genvar v = 0; v < N; v++) begin : g_vic
        logic [CNT_W-1:0] lo_cnt, hi_cnt;
        if (v > 0) begin : g_lo
            assign lo_cnt = cnt_flat[(v-1)*CNT_W +: CNT_W];
        end else begin : g_lo0
            assign lo_cnt = '0;
        end
        if (v < N-1) begin : g_hi
            assign hi_cnt = cnt_flat[(v+1)*CNT_W +: CNT_W];
        end else begin : g_hi0
            assign hi_cnt = '0;
        end
        assign risk[v] = at_risk(32'(lo_cnt), 32'(hi_cnt), 32'(limit));
    end
endmodule

// File: rtl/vrr_req_queue.sv
module vrr_req_queue #(
    parameter int unsigned N     = 16,
    parameter int unsigned ROW_W = 4,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned OCC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     risk,
    input  logic             ready,
    output logic             valid,
    output logic [ROW_W-1:0] head_row,
    output logic [N-1:0]     inq,
    output logic             push,
    output logic [OCC_W-1:0] occ
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ROW_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [N-1:0]     cand;
    logic [ROW_W-1:0] pick;
    logic             pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    // Lowest numbered row at risk and not yet waiting
    always_comb begin
        cand = risk & ~inq;
        pick = '0;
        for (int v = N - 1; v >= 0; v--) begin
            if (cand[v]) pick = ROW_W'(v);
        end
    end

    assign valid    = (occ != '0);
    assign head_row = mem[rd_ptr];
    assign pop      = valid && ready;
    assign push     = (|cand) && (32'(occ) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            inq    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= pick;
                wr_ptr      <= ptr_next(wr_ptr);
                inq[pick]   <= 1'b1;
            end
            if (pop) begin
                rd_ptr        <= ptr_next(rd_ptr);
                inq[head_row] <= 1'b0;
            end
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end
endmodule

// File: rtl/victim_row_refresher.sv
module victim_row_refresher
    import vrr_pkg::*;
#(
    parameter int unsigned N     = DEF_ROWS,
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned WIN_W = DEF_WIN_W,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned ROW_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_valid,
    input  logic [ROW_W-1:0] act_row,
    input  logic [CNT_W-1:0] act_limit,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             ref_valid,
    output logic [ROW_W-1:0] ref_row,
    input  logic             ref_ready
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);

    logic               win_expire;
    logic [N*CNT_W-1:0] cnt_flat;
    logic [N-1:0]       risk;
    logic [N-1:0]       q_inq;
    logic               q_push;
    logic [OCC_W-1:0]   q_occ;

    vrr_window_timer #(.WIN_W(WIN_W)) u_timer (
        .clk(clk), .rst(rst), .win_cycles(win_cycles), .expire(win_expire)
    );

    vrr_count_bank #(.N(N), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_row(act_row),
        .expire(win_expire), .clr_valid(ref_valid && ref_ready),
        .clr_row(ref_row), .cnt_flat(cnt_flat)
    );

    vrr_risk_detect #(.N(N), .CNT_W(CNT_W)) u_risk (
        .cnt_flat(cnt_flat), .limit(act_limit), .risk(risk)
    );

    vrr_req_queue #(.N(N), .ROW_W(ROW_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_queue (
        .clk(clk), .rst(rst), .risk(risk), .ready(ref_ready),
        .valid(ref_valid), .head_row(ref_row), .inq(q_inq),
        .push(q_push), .occ(q_occ)
    );
endmodule

// File: rtl/vrr_checker.sv
module vrr_checker #(
    parameter int unsigned N     = 16,
    parameter int unsigned ROW_W = 4,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned OCC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_valid,
    input logic             ref_ready,
    input logic [ROW_W-1:0] ref_row,
    input logic [CNT_W-1:0] act_limit,
    input logic             push,
    input logic [OCC_W-1:0] occ,
    input logic [N-1:0]     inq
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ref_valid);                                   // R1
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (32'(ref_row) < N));                            // R4
    AST_POP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_ready) |=> !inq[$past(ref_row)]);           // R6
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(occ) <= DEPTH);                                           // R8
    AST_HOLD_ROW: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_row))); // R8
    AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (rst)
        (act_limit == '0) |-> !push);                                 // R10
endmodule

bind victim_row_refresher vrr_checker #(
    .N(N), .ROW_W(ROW_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)
) u_chk (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_row(ref_row), .act_limit(act_limit), .push(q_push),
    .occ(q_occ), .inq(q_inq)
);

// File: tb/victim_row_refresher_tb.sv
module victim_row_refresher_tb;
    localparam int N     = 12;
    localparam int CNT_W = 4;
    localparam int WIN_W = 16;
    localparam int DEPTH = 3;
    localparam int ROW_W = $clog2(N);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             act_valid = 1'b0;
    logic [ROW_W-1:0] act_row = '0;
    logic [CNT_W-1:0] act_limit = '0;
    logic [WIN_W-1:0] win_cycles = '0;
    logic             ref_valid;
    logic [ROW_W-1:0] ref_row;
    logic             ref_ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    victim_row_refresher #(.N(N), .CNT_W(CNT_W), .WIN_W(WIN_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_row(act_row),
        .act_limit(act_limit), .win_cycles(win_cycles),
        .ref_valid(ref_valid), .ref_row(ref_row), .ref_ready(ref_ready)
    );

    // Behavioural reference model
    int    mcnt [N];
    bit    mpend[N];
    int    mq[$];
    int    mtick;
    int    nvec  = 0;
    int    nfail = 0;
    int    cyc   = 0;
    string tag   = "R1";

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int r = 0; r < N; r++) begin mcnt[r] = 0; mpend[r] = 0; end
            mq.delete();
            mtick = 0;
        end else begin
            bit served;
            int head;
            int victim;
            bit expired;
            int qsize;
            served = (mq.size() > 0) && ref_ready;
            head   = (mq.size() > 0) ? mq[0] : -10;
            victim = -1;
            for (int v = 0; v < N; v++) begin
                int lo;
                int hi;
                lo = (v > 0)     ? mcnt[v-1] : 0;
                hi = (v < N - 1) ? mcnt[v+1] : 0;
                if (victim < 0 && act_limit != 0 && lo + hi >= int'(act_limit) && !mpend[v])
                    victim = v;
            end
            expired = (mtick + 1 >= int'(win_cycles));
            for (int r = 0; r < N; r++) begin
                int c;
                c = mcnt[r];
                if (expired || (served && (r == head - 1 || r == head + 1))) c = 0;
                if (act_valid && int'(act_row) == r && c < CMAX) c++;
                mcnt[r] = c;
            end
            mtick = expired ? 0 : mtick + 1;
            qsize = mq.size();
            if (served) begin mpend[head] = 0; void'(mq.pop_front()); end
            if (victim >= 0 && qsize < DEPTH) begin mq.push_back(victim); mpend[victim] = 1; end
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        bit exp_v;
        int exp_r;
        exp_v = rst ? 1'b0 : (mq.size() > 0);
        exp_r = exp_v ? mq[0] : 0;
        nvec++;
        if (ref_valid !== exp_v || (exp_v && int'(ref_row) != exp_r)) begin
            nfail++;
            $display("FAIL %s cycle %0d: valid=%0b row=%0d expected valid=%0b row=%0d",
                     tag, cyc, ref_valid, ref_row, exp_v, exp_r);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic do_reset(input int lim, input int win);
        @(negedge clk);
        rst = 1'b1; act_valid = 1'b0; ref_ready = 1'b0;
        act_limit = CNT_W'(lim); win_cycles = WIN_W'(win);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hammer(input int row, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act_valid = 1'b1; act_row = ROW_W'(row);
        end
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        do_reset(4, 1000);
        idle(5);

        // R2: single aggressor, row 5 reaches the limit -> 4 then 6
        tag = "R2";
        ref_ready = 1'b1;
        hammer(5, 4);
        idle(8);
        // R6: served rows cleared their neighbours; 3 more hits are not enough
        tag = "R6";
        hammer(5, 3);
        idle(6);

        // R3: double-sided pressure on row 8
        tag = "R3";
        do_reset(4, 1000);
        ref_ready = 1'b1;
        hammer(7, 2);
        hammer(9, 2);
        idle(8);

        // R4: edge rows and out-of-range addresses
        tag = "R4";
        do_reset(3, 1000);
        ref_ready = 1'b1;
        hammer(0, 3);
        idle(5);
        hammer(N - 1, 3);
        idle(5);
        hammer(13, 8);
        hammer(N, 8);
        idle(5);

        // R5: window expiry clears counters, including a hit on the expiry cycle
        tag = "R5";
        do_reset(5, 20);
        ref_ready = 1'b1;
        hammer(2, 4);
        idle(25);
        hammer(2, 1);
        idle(5);
        do_reset(12, 20);
        ref_ready = 1'b1;
        hammer(2, 30);
        idle(10);

        // R7: duplicates suppressed, pending requests survive expiry
        tag = "R7";
        do_reset(3, 40);
        hammer(5, 3);
        hammer(5, 5);
        idle(50);
        ref_ready = 1'b1;
        idle(8);

        // R8: full queue, waiting victims, held output under back-pressure
        tag = "R8";
        do_reset(3, 1000);
        hammer(1, 3);
        hammer(5, 3);
        hammer(9, 3);
        idle(6);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            ref_ready = (i % 3 == 2);
        end
        ref_ready = 1'b1;
        idle(10);

        // R9: saturation keeps neighbours at risk while queue is full
        tag = "R9";
        do_reset(15, 60000);
        hammer(1, 15);
        hammer(9, 15);
        hammer(5, 17);
        idle(4);
        ref_ready = 1'b1;
        idle(15);

        // R10: limit zero disables detection
        tag = "R10";
        do_reset(0, 1000);
        ref_ready = 1'b1;
        hammer(5, 10);
        hammer(0, 10);
        idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule